// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line Break Control

This block sends bytes as 8N1 asynchronous frames on a single serial line. It is timed by a one-cycle tick that the surrounding logic raises at sixteen times the bit rate. Each serial bit therefore spans sixteen ticks. Bytes come in over a valid/ready handshake. The transmitter never buffers more than the frame it is currently sending.

Software controls the pin through three bits. The first is a transmit enable. The other two are a port pair that gives a direction and a level. While transmit is enabled, the transmitter owns the pin and drives it as an output. While it is disabled, the pin level and output enable come straight from the port pair, so software can park the line at mark or tri-state it. Dropping the enable resets the frame logic on the spot and throws away any partly sent frame. To send a break, software first clears the port level and then clears the enable; the line then stays low for as long as both remain cleared.

Top module: `sertx_break_top`

## Requirements
- R1: A frame is a start bit at 0, then the eight data bits with bit 0 first, then a stop bit at 1.
- R2: Every bit of a frame, start and stop included, lasts exactly sixteen tick pulses.
- R3: The frame state, the sub-bit phase and the serial level change only on cycles where `tick` is high, or when transmit is disabled; between ticks they hold.
- R4: `in_ready` is high only while `tx_en` is 1 and no byte is held or being sent. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is low on the next cycle.
- R5: After a byte is taken, the line stays at 1 until the next tick. The start bit appears in the cycle after the clock edge that samples that tick.
- R6: With `tx_en` at 1 and no frame being sent, `ser_out` is 1 and `ser_oe` is 1.
- R7: With `tx_en` at 0, `ser_out` equals `port_dat` and `ser_oe` equals `port_dir` in the same cycle. A `port_dir` of 1 means drive and 0 means tri-state.
- R8: Clearing `tx_en` ends any frame in progress at once. When `tx_en` is set again, the line is at 1, `in_ready` is high on the following cycle, and none of the aborted bits are sent.
- R9: Clearing `port_dat` and then clearing `tx_en` holds `ser_out` at 0 with `ser_oe` at 1 for as long as both stay cleared.
- R10: After reset, the frame logic is idle. With `tx_en` at 0 and the port pair at drive-high, the line rests at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle strobe at sixteen times the bit rate |
| tx_en | input | 1 | Transmit enable; 0 hands the pin to the port pair |
| port_dir | input | 1 | Port direction while disabled: 1 drive, 0 tri-state |
| port_dat | input | 1 | Port level while disabled |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | `in_data` holds a byte to send |
| in_ready | output | 1 | Transmitter can take a byte |
| ser_out | output | 1 | Serial line level |
| ser_oe | output | 1 | Output enable for the serial pin |

## Verification
The assertions check the cycle-level rules on every cycle: the state holds between ticks, a bit never ends early, the state goes back to idle the cycle after the enable drops, ready falls after a byte is taken, and an idle enabled line sits at driven mark. Only the bench scenarios can show that whole frames decode to the queued bytes in bit-0-first order, that the start bit is exactly sixteen ticks long, and that a break holds low over a long interval. They are also the only way to show that re-enabling after an abort sends nothing from the aborted frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned SERTX_OSR    = 16;
    localparam int unsigned SERTX_DATA_W = 8;

    typedef enum logic [2:0] {
        TX_IDLE  = 3'd0,
        TX_ARMED = 3'd1,
        TX_START = 3'd2,
        TX_DATA  = 3'd3,
        TX_STOP  = 3'd4
    } tx_state_e;

    typedef struct packed {
        logic level;
        logic drive;
    } pin_t;

    function automatic logic state_busy(tx_state_e s);
        return (s == TX_START) || (s == TX_DATA) || (s == TX_STOP);
    endfunction

    function automatic logic state_level(tx_state_e s, logic lsb);
        logic lvl;
        case (s)
            TX_START: lvl = 1'b0;
            TX_DATA:  lvl = lsb;
            default:  lvl = 1'b1;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/sertx_phase.sv
module sertx_phase #(
    parameter int unsigned OSR = sertx_pkg::SERTX_OSR
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic bit_done
);
    localparam int unsigned PH_W = (OSR > 1) ? $clog2(OSR) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase <= '0;
        end else if (tick) begin
            phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        end
    end

    assign bit_done = tick && (phase == PH_LAST);

    p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst || clear)
        !tick |=> $stable(phase));

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
    import sertx_pkg::*;
#(
    parameter int unsigned DATA_W = SERTX_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              tick,
    input  logic              bit_done,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              busy,
    output logic              tx_line
);
    localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    tx_state_e         state;
    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  bit_idx;

    assign in_ready = tx_en && (state == TX_IDLE);
    assign busy     = state_busy(state);
    assign tx_line  = state_level(state, shreg[0]);

    always_ff @(posedge clk) begin
        if (rst || !tx_en) begin
            state   <= TX_IDLE;
            shreg   <= '0;
            bit_idx <= '0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (in_valid) begin
                        shreg <= in_data;
                        state <= TX_ARMED;
                    end
                end
                TX_ARMED: begin
                    if (tick) state <= TX_START;
                end
                TX_START: begin
                    if (bit_done) begin
                        state   <= TX_DATA;
                        bit_idx <= '0;
                    end
                end
                TX_DATA: begin
                    if (bit_done) begin
                        shreg <= shreg >> 1;
                        if (bit_idx == IDX_LAST) begin
                            state <= TX_STOP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                TX_STOP: begin
                    if (bit_done) state <= TX_IDLE;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    p_line_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!tick && tx_en) |=> $stable(tx_line));
    p_bit_len_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_en && busy && !bit_done) |=> $stable(state));
    p_accept_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);
    p_armed_wait_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_en && state == TX_ARMED && !tick) |=> (state == TX_ARMED));
    p_abort_r8: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (state == TX_IDLE));

endmodule

// File: rtl/sertx_pinsel.sv
module sertx_pinsel
    import sertx_pkg::*;
(
    input  logic tx_en,
    input  logic tx_line,
    input  logic port_dir,
    input  logic port_dat,
    output logic ser_out,
    output logic ser_oe
);
    pin_t pin;

    always_comb begin
        if (tx_en) begin
            pin.level = tx_line;
            pin.drive = 1'b1;
        end else begin
            pin.level = port_dat;
            pin.drive = port_dir;
        end
    end

    assign ser_out = pin.level;
    assign ser_oe  = pin.drive;

endmodule

// File: rtl/sertx_break_top.sv
module sertx_break_top
    import sertx_pkg::*;
#(
    parameter int unsigned DATA_W = SERTX_DATA_W,
    parameter int unsigned OSR    = SERTX_OSR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              tx_en,
    input  logic              port_dir,
    input  logic              port_dat,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              ser_out,
    output logic              ser_oe
);
    logic busy;
    logic bit_done;
    logic tx_line;
    logic phase_clear;

    assign phase_clear = !tx_en || !busy;

    sertx_phase #(.OSR(OSR)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .clear    (phase_clear),
        .tick     (tick),
        .bit_done (bit_done)
    );

    sertx_frame #(.DATA_W(DATA_W)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .tx_en    (tx_en),
        .tick     (tick),
        .bit_done (bit_done),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .busy     (busy),
        .tx_line  (tx_line)
    );

    sertx_pinsel u_pinsel (
        .tx_en    (tx_en),
        .tx_line  (tx_line),
        .port_dir (port_dir),
        .port_dat (port_dat),
        .ser_out  (ser_out),
        .ser_oe   (ser_oe)
    );

    p_idle_mark_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !busy) |-> (ser_out && ser_oe));

endmodule

// File: tb/test_sertx_break_top.sv
module test_sertx_break_top;

    localparam int TICK_DIV = 4;
    localparam int BIT_CYC  = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic       tx_en;
    logic       port_dir;
    logic       port_dat;
    logic [7:0] in_data;
    logic       in_valid;
    logic       in_ready;
    logic       ser_out;
    logic       ser_oe;

    int n_run  = 0;
    int n_fail = 0;
    int tcnt   = 0;
    logic mon_en = 1'b0;
    logic done   = 1'b0;
    logic [7:0] exp_q[$];

    sertx_break_top i_sertx_break_top (
        .clk(clk), .rst(rst), .tick(tick), .tx_en(tx_en),
        .port_dir(port_dir), .port_dat(port_dat),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .ser_out(ser_out), .ser_oe(ser_oe)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tcnt <= (tcnt == TICK_DIV - 1) ? 0 : tcnt + 1;
        tick <= (tcnt == TICK_DIV - 1);
    end

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data  = b;
        in_valid = 1'b1;
        exp_q.push_back(b);
        @(negedge clk);
        in_valid = 1'b0;
        #1 chk("R4 ready low after accept", in_ready, 0);
    endtask

    // scoreboard monitor: decodes frames at mid-bit
    initial begin
        logic [7:0] got;
        logic [7:0] want;
        forever begin
            @(negedge clk);
            #2;
            if (mon_en && tx_en && ser_out == 1'b0) begin
                repeat (BIT_CYC / 2) @(negedge clk);
                #2 chk("R1 start bit mid", ser_out, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BIT_CYC) @(negedge clk);
                    #2 got[i] = ser_out;
                end
                repeat (BIT_CYC) @(negedge clk);
                #2 chk("R1 stop bit mid", ser_out, 1);
                if (exp_q.size() == 0) begin
                    chk("R1 unexpected frame", 1, 0);
                end else begin
                    want = exp_q.pop_front();
                    chk("R1 frame data", got, want);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int lows;
        int bad;
        tick = 1'b0; rst = 1'b1; tx_en = 1'b0; port_dir = 1'b1; port_dat = 1'b1;
        in_data = '0; in_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk("R10 reset line mark", ser_out, 1);
        chk("R10 reset oe", ser_oe, 1);
        chk("R4 ready low while disabled", in_ready, 0);

        port_dir = 1'b0;
        #1 chk("R7 tri-state when disabled", ser_oe, 0);
        port_dir = 1'b1; port_dat = 1'b0;
        #1 chk("R7 line follows port bit", ser_out, 0);
        port_dat = 1'b1;

        @(negedge clk);
        tx_en = 1'b1;
        #1 chk("R6 enabled idle line", ser_out, 1);
        chk("R6 enabled idle oe", ser_oe, 1);
        chk("R4 ready when enabled idle", in_ready, 1);

        // R5 / R2: start waits for tick, start lasts 16 ticks (0x55 has bit0 = 1)
        mon_en = 1'b1;
        send_byte(8'h55);
        bad = 0;
        #1;
        while (!tick) begin
            if (ser_out != 1'b1) bad++;
            @(negedge clk); #1;
        end
        if (ser_out != 1'b1) bad++;
        chk("R5 mark until tick", bad, 0);
        @(negedge clk); #1;
        chk("R5 start after tick", ser_out, 0);
        lows = 0;
        while (ser_out == 1'b0 && lows < 1000) begin
            lows++;
            @(negedge clk); #1;
        end
        chk("R2 start bit length in cycles", lows, BIT_CYC);

        send_byte(8'hA5);
        send_byte(8'h00);
        send_byte(8'hFF);
        send_byte(8'h3C);
        send_byte(8'h81);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (BIT_CYC) @(negedge clk);

        // R8 / R9: abort mid-frame into break
        mon_en = 1'b0;
        repeat (BIT_CYC) @(negedge clk);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data = 8'hF0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3 * BIT_CYC + 7) @(negedge clk);
        port_dat = 1'b0;
        @(negedge clk);
        tx_en = 1'b0;
        #1 chk("R9 break immediate low", ser_out, 0);
        chk("R9 break oe", ser_oe, 1);
        chk("R8 ready low while disabled", in_ready, 0);
        bad = 0;
        repeat (20 * BIT_CYC) begin
            @(negedge clk); #1;
            if (ser_out != 1'b0 || ser_oe != 1'b1) bad++;
        end
        chk("R9 break held low", bad, 0);

        port_dat = 1'b1;
        #1 chk("R7 mark restored by port bit", ser_out, 1);
        @(negedge clk);
        tx_en = 1'b1;
        #1 chk("R8 mark on re-enable", ser_out, 1);
        @(negedge clk); #1;
        chk("R8 ready after re-enable", in_ready, 1);
        bad = 0;
        repeat (12 * BIT_CYC) begin
            @(negedge clk); #1;
            if (ser_out != 1'b1) bad++;
        end
        chk("R8 no leftover bits", bad, 0);

        // frame after abort decodes cleanly
        mon_en = 1'b1;
        send_byte(8'h6B);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (BIT_CYC) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule